// File: doc/BRIEF.md
# Genlocked Raster Timing Generator

This block produces the horizontal sync, vertical sync and active-video enable for one fixed video raster. All raster sizes are parameters, and the defaults describe a 1920x1080 progressive frame of 2200 x 1125 pixel clocks. With no external reference the raster free-runs. When the external reference is enabled, the block compares its own position against every rising edge of a master vertical sync input. If the phase error is larger than a programmable tolerance, the block reloads its counters so that the next output frame starts in step with the master. If the error is within the tolerance, the counters are left alone. A lock flag reports whether the stream has stayed aligned.

A master horizontal sync may also be supplied. For progressive output it is not needed, because the vertical sync alone sets the phase. For an interlaced raster, the level of the master horizontal sync at the instant the master vertical sync rises selects the field flag of the next frame. Without it, the field flag simply alternates from frame to frame. Each master input passes through a polarity inverter and a two-flop synchroniser before its edges are used.

The tolerance `LOCK_TOL` is counted in pixel clocks. Three cycles of a 27 MHz reference are about 16 pixel clocks at 148.5 MHz, which is the default. A master stream whose line or frame totals differ from the programmed raster is not tracked: its phase walks out of the window and the block reports loss of lock.

Top module: `vtg_genlock`

## Requirements
- R1: Free-running, the raster has a period of HT = HA+HFP+HSW+HBP clocks per line and VT = VA+VFP+VSW+VBP lines per frame.
  - hs_o is high for HSW clocks, starting HA+HFP clocks into each line.
  - vs_o is high for the VSW whole lines that start at line VA+VFP.
  - de_o is high for the first HA clocks of each of the first VA lines.
- R2: While rst_i is high, every output is low: hs_o, vs_o, de_o, field_o and lock_o.
- R3: Suppose a master vertical-sync rising edge arrives more than LOCK_TOL clocks away from alignment. On every later frame, vs_o then rises in the very clock cycle in which the master pin was first sampled high. That is, the offset is 0.
- R4: A master edge within LOCK_TOL clocks of alignment moves nothing. This holds at exactly +LOCK_TOL and at exactly -LOCK_TOL. vs_o keeps its own phase, so the offset measured at the ports equals the negated lateness.
- R5: A master edge outside the window clears lock_o within 3 clocks. lock_o rises only after two consecutive in-window edges that follow the re-alignment.
- R6: If no master vertical-sync edge is detected for 1.5 nominal frame periods (3*HT*VT/2 clocks), lock_o falls. Before that time it holds.
- R7: A master frame whose period differs from HT*VT is not followed. Its phase error grows every frame until it exceeds LOCK_TOL, and lock_o then falls.
- R8: sync_pol_i[0] = 1 inverts the master vertical sync and sync_pol_i[1] = 1 inverts the master horizontal sync. With sync_pol_i[0] = 1, a falling pin edge aligns the raster exactly as a rising edge does with 0.
- R9: With ext_hs_en_i = 0, the block locks from the vertical sync alone. With interlace_i = 0, field_o stays 0.
- R10: With interlace_i = 1 and ext_hs_en_i = 1, the frame that follows a master vertical-sync edge carries field_o = 0 if the master horizontal sync was high at that edge, and field_o = 1 if it was low. With ext_hs_en_i = 0, field_o inverts at every frame start.
- R11: With ext_en_i = 0, master edges are ignored. The raster keeps its free-running period of HT*VT clocks and lock_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_en_i | input | 1 | Follow the master vertical sync |
| ext_hs_en_i | input | 1 | Use the master horizontal sync for field selection |
| interlace_i | input | 1 | Interlaced raster: drive field_o |
| sync_pol_i | input | 2 | Bit 0 inverts ext_vs_i, bit 1 inverts ext_hs_i |
| ext_vs_i | input | 1 | Master vertical sync, asynchronous |
| ext_hs_i | input | 1 | Master horizontal sync, asynchronous |
| hs_o | output | 1 | Horizontal sync, active high |
| vs_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Active-video enable |
| field_o | output | 1 | Field flag, 0 for the first field |
| lock_o | output | 1 | Aligned to the master for two or more frames |

## Verification
The internal state is the pair of raster counters, the consecutive-good flag, the silence counter and the pending field. Each of these shows up at the ports within at most one frame.
- A counter slip or a missed reload moves the vs_o rise away from the master pin edge. This is visible on the very next master edge.
- A wrong window comparison either moves the raster when it should not, or leaves it when it should move. It also shows in lock_o three clocks after the edge.
- A wrong pending field shows in field_o at the next frame start, about (VSW+VBP) lines after the edge.
- A faulty silence counter shows as lock_o falling too early or too late around the 1.5-frame mark.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Pair of master sync signals after polarity correction.
  typedef struct packed {
    logic vs;
    logic hs;
  } xsync_t;

  // Signed distance from tgt to pos on a circle of length total,
  // folded into the range -total/2 .. +total/2.
  function automatic int wrap_err(int pos, int tgt, int total);
    int d;
    d = pos - tgt;
    if (d > total / 2)
      d = d - total;
    else if (d < -(total / 2))
      d = d + total;
    return d;
  endfunction

endpackage

// File: rtl/vtg_sync2.sv
module vtg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    logic stab;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d_i[i];
        stab <= meta;
      end
    end

    assign q_o[i] = stab;
  end

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
  parameter  int HA  = 1920,
  parameter  int HFP = 88,
  parameter  int HSW = 44,
  parameter  int HBP = 148,
  parameter  int VA  = 1080,
  parameter  int VFP = 4,
  parameter  int VSW = 5,
  parameter  int VBP = 36,
  localparam int HT  = HA + HFP + HSW + HBP,
  localparam int VT  = VA + VFP + VSW + VBP,
  localparam int HW  = $clog2(HT),
  localparam int VW  = $clog2(VT)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [HW-1:0] load_h_i,
  input  logic [VW-1:0] load_v_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          sof_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic          de_o
);

  localparam logic [HW-1:0] H_LAST = HW'(HT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(VT - 1);
  localparam logic [HW-1:0] H_ACT  = HW'(HA);
  localparam logic [HW-1:0] HS_ON  = HW'(HA + HFP);
  localparam logic [HW-1:0] HS_OFF = HW'(HA + HFP + HSW);
  localparam logic [VW-1:0] V_ACT  = VW'(VA);
  localparam logic [VW-1:0] VS_ON  = VW'(VA + VFP);
  localparam logic [VW-1:0] VS_OFF = VW'(VA + VFP + VSW);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  // Position counters; a load overrides the normal advance.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (load_i) begin
      h_q <= load_h_i;
      v_q <= load_v_i;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  // Registered decode: outputs trail the counters by one clock.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hs_o <= 1'b0;
      vs_o <= 1'b0;
      de_o <= 1'b0;
    end else begin
      hs_o <= (h_q >= HS_ON) && (h_q < HS_OFF);
      vs_o <= (v_q >= VS_ON) && (v_q < VS_OFF);
      de_o <= (h_q < H_ACT) && (v_q < V_ACT);
    end
  end

  assign h_o   = h_q;
  assign v_o   = v_q;
  assign sof_o = (h_q == '0) && (v_q == '0);

  // R1: horizontal position never leaves the line
  p_h_bound_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    h_q <= H_LAST);

  // R1: end of line returns to pixel 0 and advances or wraps the line
  p_line_advance_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && h_q == H_LAST) |=> (h_q == '0) &&
                                    ((v_q == '0) || (v_q == $past(v_q) + 1'b1)));

  // R1: vertical sync lines carry no active video
  p_vs_blank_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    vs_o |-> !de_o);

endmodule

// File: rtl/vtg_lock.sv
module vtg_lock #(
  parameter  int TOTAL = 2475000,
  parameter  int TOL   = 16,
  parameter  int TGT   = 0,
  localparam int PW    = $clog2(TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          det_i,
  input  logic [PW-1:0] pos_i,
  output logic          reload_o,
  output logic          lock_o
);

  localparam int            LIMIT   = (3 * TOTAL) / 2;
  localparam int            TW      = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIMIT_T = TW'(LIMIT);

  int            err;
  logic          outside;
  logic          seen_q;
  logic [TW-1:0] quiet_q;

  always_comb begin
    err     = vtg_pkg::wrap_err(int'(pos_i), TGT, TOTAL);
    outside = (err > TOL) || (err < -TOL);
  end

  assign reload_o = en_i && det_i && outside;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      quiet_q <= '0;
      seen_q  <= 1'b0;
      lock_o  <= 1'b0;
    end else if (det_i) begin
      quiet_q <= '0;
      if (outside) begin
        seen_q <= 1'b0;
        lock_o <= 1'b0;
      end else begin
        seen_q <= 1'b1;
        if (seen_q) lock_o <= 1'b1;
      end
    end else if (quiet_q == LIMIT_T) begin
      seen_q <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  // R5: a re-alignment always clears the lock flag
  p_reload_unlock_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    reload_o |=> !lock_o);

  // R6: a master silence of 1.5 frames clears the lock flag
  p_silence_unlock_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !det_i && quiet_q == LIMIT_T) |=> !lock_o);

  // R11: no lock while the master reference is disabled
  p_disabled_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !lock_o);

endmodule

// File: rtl/vtg_genlock.sv
module vtg_genlock #(
  parameter int HA       = 1920,
  parameter int HFP      = 88,
  parameter int HSW      = 44,
  parameter int HBP      = 148,
  parameter int VA       = 1080,
  parameter int VFP      = 4,
  parameter int VSW      = 5,
  parameter int VBP      = 36,
  parameter int LOCK_TOL = 16
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       ext_en_i,
  input  logic       ext_hs_en_i,
  input  logic       interlace_i,
  input  logic [1:0] sync_pol_i,
  input  logic       ext_vs_i,
  input  logic       ext_hs_i,
  output logic       hs_o,
  output logic       vs_o,
  output logic       de_o,
  output logic       field_o,
  output logic       lock_o
);

  localparam int HT        = HA + HFP + HSW + HBP;
  localparam int VT        = VA + VFP + VSW + VBP;
  localparam int TOTAL     = HT * VT;
  localparam int HW        = $clog2(HT);
  localparam int VW        = $clog2(VT);
  localparam int PW        = $clog2(TOTAL);
  // Clocks from the first sampling edge to the edge-detect cycle.
  localparam int ALIGN_LAT = 2;
  localparam int SYNC_LINE = VA + VFP;
  localparam int TGT       = SYNC_LINE * HT + ALIGN_LAT;

  vtg_pkg::xsync_t raw, syn;
  logic            vs_d;
  logic            det;
  logic [HW-1:0]   h_cnt;
  logic [VW-1:0]   v_cnt;
  logic [PW-1:0]   pos;
  logic            sof;
  logic            reload;
  logic            pend_q;
  logic            pvld_q;
  logic            field_q;

  assign raw.vs = ext_vs_i ^ sync_pol_i[0];
  assign raw.hs = ext_hs_i ^ sync_pol_i[1];

  vtg_sync2 #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw),
    .q_o   (syn)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) vs_d <= 1'b0;
    else       vs_d <= syn.vs;
  end

  assign det = syn.vs & ~vs_d;
  assign pos = PW'(v_cnt) * PW'(HT) + PW'(h_cnt);

  vtg_raster #(
    .HA(HA), .HFP(HFP), .HSW(HSW), .HBP(HBP),
    .VA(VA), .VFP(VFP), .VSW(VSW), .VBP(VBP)
  ) u_raster (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (reload),
    .load_h_i (HW'(ALIGN_LAT + 1)),
    .load_v_i (VW'(SYNC_LINE)),
    .h_o      (h_cnt),
    .v_o      (v_cnt),
    .sof_o    (sof),
    .hs_o     (hs_o),
    .vs_o     (vs_o),
    .de_o     (de_o)
  );

  vtg_lock #(
    .TOTAL (TOTAL),
    .TOL   (LOCK_TOL),
    .TGT   (TGT)
  ) u_lock (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (ext_en_i),
    .det_i    (det),
    .pos_i    (pos),
    .reload_o (reload),
    .lock_o   (lock_o)
  );

  // Field: a decoded field waits for the next frame start; without one
  // the flag alternates.
  always_ff @(posedge clk_i) begin
    if (rst_i || !interlace_i) begin
      field_q <= 1'b0;
      pend_q  <= 1'b0;
      pvld_q  <= 1'b0;
    end else if (sof) begin
      field_q <= pvld_q ? pend_q : ~field_q;
      pvld_q  <= 1'b0;
    end else if (det && ext_en_i && ext_hs_en_i) begin
      pend_q <= ~syn.hs;
      pvld_q <= 1'b1;
    end
  end

  assign field_o = field_q;

  // R9: a progressive raster never reports the second field
  p_prog_field_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !interlace_i |=> !field_o);

endmodule

// File: tb/vtg_genlock_bench.sv
`timescale 1ns/1ps
module vtg_genlock_bench;

  localparam int HA = 16, HFP = 4, HSW = 4, HBP = 6;
  localparam int VA = 8,  VFP = 2, VSW = 2, VBP = 3;
  localparam int HT = HA + HFP + HSW + HBP;
  localparam int VT = VA + VFP + VSW + VBP;
  localparam int N  = HT * VT;
  localparam int TOL  = 3;
  localparam int SKIP = 9999;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_en = 1'b0, hs_en = 1'b0, ilace = 1'b0;
  logic [1:0] pol = 2'b00;
  logic       xvs = 1'b0, xhs = 1'b0;
  logic       hs, vs, de, field, lock;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rise_last = -1;
  int rise_prev = -1;
  logic vs_p = 1'b0;

  typedef struct {
    string rq_o;
    string rq_l;
    int    tp;
    int    off;
    int    lk;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vtg_genlock #(
    .HA(HA), .HFP(HFP), .HSW(HSW), .HBP(HBP),
    .VA(VA), .VFP(VFP), .VSW(VSW), .VBP(VBP), .LOCK_TOL(TOL)
  ) u_vtg_genlock (
    .clk_i(clk), .rst_i(rst), .ext_en_i(ext_en), .ext_hs_en_i(hs_en),
    .interlace_i(ilace), .sync_pol_i(pol), .ext_vs_i(xvs), .ext_hs_i(xhs),
    .hs_o(hs), .vs_o(vs), .de_o(de), .field_o(field), .lock_o(lock)
  );

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: records output VS rises, pops expectations and compares.
  always @(negedge clk) begin
    item_t it;
    if (vs && !vs_p) begin
      rise_prev = rise_last;
      rise_last = cyc;
    end
    vs_p = vs;
    if (exp_q.size() > 0 && cyc >= exp_q[0].tp + 6) begin
      it = exp_q.pop_front();
      if (it.off != SKIP) chk({it.rq_o, " vs offset"}, rise_last - it.tp, it.off);
      if (it.lk >= 0)     chk({it.rq_l, " lock"}, int'(lock), it.lk);
    end
  end

  // Driver: one master frame of length per, starting at this negedge.
  task automatic frame(int per, int off, string rq_o, int lk, string rq_l,
                       int hlv, int fld);
    item_t it;
    xvs = 1'b1 ^ pol[0];
    xhs = hlv[0] ^ pol[1];
    it.rq_o = rq_o; it.rq_l = rq_l; it.tp = cyc + 1; it.off = off; it.lk = lk;
    if (off != SKIP || lk >= 0) exp_q.push_back(it);
    tick(VSW * HT);
    xvs = pol[0];
    xhs = pol[1];
    tick(200 - VSW * HT);
    if (fld >= 0) chk("R10 field", int'(field), fld);
    tick(per - 200);
  endtask

  initial begin
    int de_n, hs_n, vs_n, hs_r;
    logic hs_q, vs_q;
    tick(5);
    chk("R2 hs", int'(hs), 0);
    chk("R2 vs", int'(vs), 0);
    chk("R2 de", int'(de), 0);
    chk("R2 field", int'(field), 0);
    chk("R2 lock", int'(lock), 0);
    rst = 1'b0;

    // R1 free-run raster over one frame
    vs_q = vs;
    while (!(vs && !vs_q)) begin vs_q = vs; tick(1); end
    de_n = 0; hs_n = 0; vs_n = 0; hs_r = 0; hs_q = hs;
    for (int i = 0; i < N; i++) begin
      de_n += int'(de);
      hs_n += int'(hs);
      vs_n += int'(vs);
      if (hs && !hs_q) hs_r++;
      hs_q = hs;
      vs_q = vs;
      tick(1);
    end
    chk("R1 de count", de_n, HA * VA);
    chk("R1 hs high", hs_n, HSW * VT);
    chk("R1 vs high", vs_n, VSW * HT);
    chk("R1 hs pulses", hs_r, VT);
    chk("R1 frame period", int'(vs && !vs_q), 1);

    // R3/R5/R9: acquire from vertical sync alone
    ext_en = 1'b1;
    tick(77);
    frame(N, SKIP, "", -1, "", 0, -1);
    frame(N, 0, "R3", 0, "R5", 0, -1);
    frame(N, 0, "R3", 1, "R5", 0, -1);
    frame(N, 0, "R9", 1, "R9", 0, -1);
    chk("R9 field", int'(field), 0);

    // R4: lateness of exactly TOL is tolerated
    tick(3);
    frame(N, -3, "R4", 1, "R4", 0, -1);
    frame(N, -3, "R4", 1, "R4", 0, -1);
    // R5: one more clock late is outside the window
    tick(1);
    frame(N, SKIP, "", 0, "R5", 0, -1);
    frame(N, 0, "R3", 0, "R5", 0, -1);
    frame(N, 0, "R3", 1, "R5", 0, -1);
    // R4: earliness of exactly TOL is tolerated
    frame(N - 3, 0, "R3", 1, "R5", 0, -1);
    frame(N, 3, "R4", 1, "R4", 0, -1);

    // R7: long master frames drift out of the window
    frame(N + 2, 3, "R7", 1, "R7", 0, -1);
    frame(N + 2, 1, "R7", 1, "R7", 0, -1);
    frame(N + 2, -1, "R7", 1, "R7", 0, -1);
    frame(N + 2, -3, "R7", 1, "R7", 0, -1);
    frame(N + 2, SKIP, "", 0, "R7", 0, -1);
    frame(N, -2, "R4", 0, "R5", 0, -1);
    frame(N, -2, "R4", 1, "R5", 0, -1);

    // R6: master goes silent
    tick(N / 4);
    chk("R6 lock held", int'(lock), 1);
    tick(N / 4 + 20);
    chk("R6 lock dropped", int'(lock), 0);

    // R8: inverted master vertical sync
    pol = 2'b01;
    xvs = 1'b1;
    frame(N, SKIP, "", -1, "", 0, -1);
    frame(N, 0, "R8", 0, "R8", 0, -1);
    frame(N, 0, "R8", 1, "R8", 0, -1);
    frame(N, 0, "R8", 1, "R8", 0, -1);
    pol = 2'b00;
    xvs = 1'b0;

    // R10: field selection from the master horizontal sync
    ilace = 1'b1;
    hs_en = 1'b1;
    frame(N, SKIP, "", -1, "", 1, 0);
    frame(N, 0, "R10", -1, "", 0, 1);
    frame(N, 0, "R10", -1, "", 0, 1);
    frame(N, 0, "R10", -1, "", 1, 0);
    hs_en = 1'b0;
    frame(N, 0, "R10", -1, "", 1, 1);
    frame(N, 0, "R10", -1, "", 1, 0);

    // R11: master ignored when disabled
    ext_en = 1'b0;
    ilace  = 1'b0;
    tick(100);
    frame(N, SKIP, "", 0, "R11", 0, -1);
    frame(N, SKIP, "", 0, "R11", 0, -1);
    chk("R11 free period", rise_last - rise_prev, N);
    chk("R11 lock", int'(lock), 0);

    tick(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule